// File: doc/BRIEF.md
# Serial Receiver with Multiprocessor Sleep and Wake-up

This block receives asynchronous serial characters on a single line. It samples the line on an oversampling tick that runs at sixteen times the bit rate. A character is one low start bit, then eight or nine data bits sent least significant first, then one high stop bit. A configuration input picks between eight and nine data bits. Each good character is placed in a receive holding register, and a data-ready flag goes high. A bad stop bit raises a framing-error flag. A separate flag reports that the line has stayed high for one whole character time.

Several receivers can share one line. Each node decides, from the opening characters of a message, whether that message is addressed to it. If it is not, software pulses a sleep request. While the node sleeps, its flags stay quiet and it does not store characters. The hardware ends the sleep by itself in one of two ways, chosen by a configuration input:
- An idle line lasting one full character time ends it.
- A received character whose top data bit is 1 ends it. Such a character is treated as an address.

A second input chooses where idle counting begins. A third lets the idle flag report even while the node sleeps.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset the outputs `rx_data`, `rx_ready`, `line_idle`, `frame_err` and `asleep` are all 0.
- R2: Each character is stored into `rx_data` and `rx_ready` rises.
  - With `cfg_nine`=0, there are 8 data bits, sent LSB first. They land in `rx_data[7:0]`, and `rx_data[8]` is 0.
  - With `cfg_nine`=1, there are 9 data bits, and `rx_data[8]` is the ninth bit received.
- R3: The receiver detects a falling edge, then samples the line 8 oversample ticks later. The start bit is accepted only if the line is still low at that sample. Otherwise the receiver goes back to hunting, and nothing is stored or flagged.
- R4: If the stop-bit sample is 0, `frame_err` is set and that character is not stored. While `frame_err` is 1, no character is stored. `err_clr` clears `frame_err`.
- R5: `rdy_clr` clears only `rx_ready`, and `idle_clr` clears only `line_idle`.
- R6: `line_idle` rises once the line has been high for one character time of oversample ticks: 10×16 ticks when `cfg_nine`=0 and 11×16 ticks when `cfg_nine`=1. It rises at most once per received character.
- R7: The setting of `cfg_idle_after_stop` decides when idle counting starts:
  - When it is 0, counting starts at start-bit acceptance, so high data bits and the stop bit count toward idle.
  - When it is 1, counting starts at the stop-bit sample.
- R8: While `asleep` is 1, `rx_ready` and `frame_err` do not set and no character is stored.
- R9: With `cfg_wake_addr`=0, an idle detection clears `asleep`.
  - If `cfg_idle_in_sleep` is 0, an idle detection made while asleep does not set `line_idle`.
  - If `cfg_idle_in_sleep` is 1, every idle detection sets `line_idle`.
- R10: With `cfg_wake_addr`=1, a character whose top data bit is 1 clears `asleep` before its stop bit, and it is stored. That top bit is bit 7 when `cfg_nine`=0 and bit 8 when `cfg_nine`=1. Characters whose top bit is 0, and idle time, leave `asleep` at 1.
- R11: The timing of a `sleep_req` pulse depends on what the receiver is doing:
  - If the receiver is hunting, the pulse sets `asleep` on the next cycle.
  - During a character, the request is held until the receiver returns to hunting. The character in progress is still received.
  - A wake event in the same cycle as the request, or while it is held, cancels the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_wake_addr | input | 1 | 1 selects address-bit wake-up, 0 selects idle-line wake-up |
| cfg_idle_after_stop | input | 1 | 1 starts idle counting at the stop bit, 0 at the start bit |
| cfg_idle_in_sleep | input | 1 | 1 lets idle detection set `line_idle` while asleep |
| sleep_req | input | 1 | Pulse requesting sleep |
| rdy_clr | input | 1 | Pulse clearing `rx_ready` |
| idle_clr | input | 1 | Pulse clearing `line_idle` |
| err_clr | input | 1 | Pulse clearing `frame_err` |
| rx_data | output | 9 | Last stored character |
| rx_ready | output | 1 | Character stored since last clear |
| line_idle | output | 1 | Idle line detected |
| frame_err | output | 1 | Stop bit read as 0 |
| asleep | output | 1 | Receiver sleeping |

## Verification
The hardest state to reach from the ports is a sleep request that is being held while a wake event arrives. To get there, the bench pulses `sleep_req` partway through the data bits of a character whose top bit is 1, with address wake-up selected. The request is then held when the address bit is sampled. Done the same way with a top bit of 0, the bench shows the held request being applied at the end of the character, after that character has been stored. The two idle start points and the two character lengths are told apart by checking `line_idle` half a bit time either side of the threshold that the requirements predict.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic nine;
        logic wake_addr;
        logic idle_after_stop;
        logic idle_in_sleep;
    } rx_cfg_t;

    typedef struct packed {
        logic       start_ok;
        logic       msb_seen;
        logic       msb_val;
        logic       frame_done;
        logic       stop_ok;
        logic [8:0] data;
    } eng_evt_t;

    function automatic logic [3:0] data_bits(input logic nine);
        return nine ? 4'd9 : 4'd8;
    endfunction

    function automatic logic [3:0] char_bits(input logic nine);
        return data_bits(nine) + 4'd2;
    endfunction

endpackage

// File: rtl/uwr_bit_engine.sv
module uwr_bit_engine
    import uwr_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     nine,
    output logic     busy,
    output eng_evt_t evt
);
    localparam int HALF  = OS_RATE / 2;
    localparam int CNT_W = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;

    rx_state_e        st;
    logic [CNT_W-1:0] tcnt;
    logic [3:0]       bidx;
    logic [7:0]       shreg;
    logic             last_bit;
    logic             mid_hit;
    logic             full_hit;

    always_comb begin
        last_bit = (bidx == (data_bits(nine) - 4'd1));
        mid_hit  = (tcnt == CNT_W'(HALF - 1));
        full_hit = (tcnt == CNT_W'(OS_RATE - 1));
        busy     = (st != ST_HUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_HUNT;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            evt   <= '0;
        end else begin
            evt.start_ok   <= 1'b0;
            evt.msb_seen   <= 1'b0;
            evt.frame_done <= 1'b0;
            if (tick) begin
                unique case (st)
                    ST_HUNT: begin
                        if (!rxd) begin
                            st   <= ST_START;
                            tcnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (mid_hit) begin
                            tcnt <= '0;
                            if (!rxd) begin
                                st           <= ST_DATA;
                                bidx         <= '0;
                                evt.start_ok <= 1'b1;
                            end else begin
                                st <= ST_HUNT;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (full_hit) begin
                            tcnt <= '0;
                            if (last_bit) begin
                                evt.msb_seen <= 1'b1;
                                evt.msb_val  <= rxd;
                                evt.data     <= nine ? {rxd, shreg}
                                                     : {1'b0, rxd, shreg[7:1]};
                                st           <= ST_STOP;
                            end else begin
                                shreg <= {rxd, shreg[7:1]};
                                bidx  <= bidx + 4'd1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (full_hit) begin
                            tcnt           <= '0;
                            evt.frame_done <= 1'b1;
                            evt.stop_ok    <= rxd;
                            st             <= ST_HUNT;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: st <= ST_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/uwr_idle_detect.sv
module uwr_idle_detect
    import uwr_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic nine,
    input  logic arm,
    output logic idle_evt
);
    localparam int MAX_TICKS = 11 * OS_RATE;
    localparam int LIM_W     = $clog2(MAX_TICKS + 1);

    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] limit;
    logic             armed;

    always_comb begin
        limit = LIM_W'(char_bits(nine)) * LIM_W'(OS_RATE) - LIM_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (arm) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (tick && armed) begin
                if (!rxd) begin
                    cnt <= '0;
                end else if (cnt == limit) begin
                    idle_evt <= 1'b1;
                    armed    <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uwr_flag_ctrl.sv
module uwr_flag_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       wake_addr,
    input  logic       idle_in_sleep,
    input  logic       busy,
    input  logic       msb_seen,
    input  logic       msb_val,
    input  logic       frame_done,
    input  logic       stop_ok,
    input  logic [8:0] char_data,
    input  logic       idle_evt,
    input  logic       sleep_req,
    input  logic       rdy_clr,
    input  logic       idle_clr,
    input  logic       err_clr,
    output logic [8:0] rx_data,
    output logic       rx_ready,
    output logic       line_idle,
    output logic       frame_err,
    output logic       asleep,
    output logic       pend
);
    logic wake;
    logic sleep_go;
    logic store;
    logic fe_set;
    logic idle_set;

    always_comb begin
        wake     = wake_addr ? (msb_seen && msb_val) : idle_evt;
        sleep_go = (sleep_req || pend) && !busy;
        store    = frame_done && stop_ok && !frame_err && !asleep;
        fe_set   = frame_done && !stop_ok && !asleep;
        idle_set = idle_evt && (!asleep || idle_in_sleep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b0;
            pend   <= 1'b0;
        end else if (wake) begin
            asleep <= 1'b0;
            pend   <= 1'b0;
        end else if (sleep_go) begin
            asleep <= 1'b1;
            pend   <= 1'b0;
        end else if (sleep_req) begin
            pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_ready  <= 1'b0;
            line_idle <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (store) begin
                rx_data  <= char_data;
                rx_ready <= 1'b1;
            end else if (rdy_clr) begin
                rx_ready <= 1'b0;
            end
            if (idle_set) begin
                line_idle <= 1'b1;
            end else if (idle_clr) begin
                line_idle <= 1'b0;
            end
            if (fe_set) begin
                frame_err <= 1'b1;
            end else if (err_clr) begin
                frame_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uwr_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       cfg_nine,
    input  logic       cfg_wake_addr,
    input  logic       cfg_idle_after_stop,
    input  logic       cfg_idle_in_sleep,
    input  logic       sleep_req,
    input  logic       rdy_clr,
    input  logic       idle_clr,
    input  logic       err_clr,
    output logic [8:0] rx_data,
    output logic       rx_ready,
    output logic       line_idle,
    output logic       frame_err,
    output logic       asleep
);
    rx_cfg_t  cfg;
    eng_evt_t evt;
    logic     busy;
    logic     pend;
    logic     idle_arm;
    logic     idle_evt;

    always_comb begin
        cfg.nine            = cfg_nine;
        cfg.wake_addr       = cfg_wake_addr;
        cfg.idle_after_stop = cfg_idle_after_stop;
        cfg.idle_in_sleep   = cfg_idle_in_sleep;
        idle_arm = cfg.idle_after_stop ? evt.frame_done : evt.start_ok;
    end

    uwr_bit_engine #(.OS_RATE(OS_RATE)) u_eng (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .rxd  (rxd),
        .nine (cfg.nine),
        .busy (busy),
        .evt  (evt)
    );

    uwr_idle_detect #(.OS_RATE(OS_RATE)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .rxd      (rxd),
        .nine     (cfg.nine),
        .arm      (idle_arm),
        .idle_evt (idle_evt)
    );

    uwr_flag_ctrl u_flags (
        .clk           (clk),
        .rst           (rst),
        .wake_addr     (cfg.wake_addr),
        .idle_in_sleep (cfg.idle_in_sleep),
        .busy          (busy),
        .msb_seen      (evt.msb_seen),
        .msb_val       (evt.msb_val),
        .frame_done    (evt.frame_done),
        .stop_ok       (evt.stop_ok),
        .char_data     (evt.data),
        .idle_evt      (idle_evt),
        .sleep_req     (sleep_req),
        .rdy_clr       (rdy_clr),
        .idle_clr      (idle_clr),
        .err_clr       (err_clr),
        .rx_data       (rx_data),
        .rx_ready      (rx_ready),
        .line_idle     (line_idle),
        .frame_err     (frame_err),
        .asleep        (asleep),
        .pend          (pend)
    );

endmodule

// File: rtl/uwr_checker.sv
module uwr_checker (
    input logic       clk,
    input logic       rst,
    input logic [8:0] rx_data,
    input logic       rx_ready,
    input logic       line_idle,
    input logic       frame_err,
    input logic       asleep,
    input logic       cfg_idle_in_sleep,
    input logic       sleep_req,
    input logic       pend,
    input logic       busy
);
    AST_NO_STORE_UNDER_FE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> !$past(frame_err)); // R4
    AST_NO_READY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> !$past(asleep)); // R8
    AST_NO_FE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> !$past(asleep)); // R8
    AST_DATA_MOVES_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_ready); // R2
    AST_IDLE_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(line_idle) |-> (!$past(asleep) || $past(cfg_idle_in_sleep))); // R9
    AST_SLEEP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> ($past(sleep_req) || $past(pend))); // R11
    AST_SLEEP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> !$past(busy)); // R11
endmodule

bind uart_wake_rx uwr_checker u_chk (
    .clk               (clk),
    .rst               (rst),
    .rx_data           (rx_data),
    .rx_ready          (rx_ready),
    .line_idle         (line_idle),
    .frame_err         (frame_err),
    .asleep            (asleep),
    .cfg_idle_in_sleep (cfg_idle_in_sleep),
    .sleep_req         (sleep_req),
    .pend              (pend),
    .busy              (busy)
);

// File: tb/uart_wake_rx_tb.sv
module uart_wake_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_nine = 1'b0;
    logic       cfg_wake_addr = 1'b0;
    logic       cfg_idle_after_stop = 1'b0;
    logic       cfg_idle_in_sleep = 1'b0;
    logic       sleep_req = 1'b0;
    logic       rdy_clr = 1'b0;
    logic       idle_clr = 1'b0;
    logic       err_clr = 1'b0;
    logic [8:0] rx_data;
    logic       rx_ready;
    logic       line_idle;
    logic       frame_err;
    logic       asleep;

    int  n_chk = 0;
    int  n_fail = 0;
    logic mid_sleep_seen = 1'b0;

    localparam int BIT_CLKS = 32;

    always #5 clk = ~clk;

    uart_wake_rx u_dut (
        .clk                 (clk),
        .rst                 (rst),
        .os_tick             (os_tick),
        .rxd                 (rxd),
        .cfg_nine            (cfg_nine),
        .cfg_wake_addr       (cfg_wake_addr),
        .cfg_idle_after_stop (cfg_idle_after_stop),
        .cfg_idle_in_sleep   (cfg_idle_in_sleep),
        .sleep_req           (sleep_req),
        .rdy_clr             (rdy_clr),
        .idle_clr            (idle_clr),
        .err_clr             (err_clr),
        .rx_data             (rx_data),
        .rx_ready            (rx_ready),
        .line_idle           (line_idle),
        .frame_err           (frame_err),
        .asleep              (asleep)
    );

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    task automatic clr_all();
        @(negedge clk);
        rdy_clr = 1'b1; idle_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0; idle_clr = 1'b0; err_clr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic send_char(input logic [8:0] d, input logic stop, input logic mid_sleep);
        int nb;
        nb = cfg_nine ? 9 : 8;
        rxd = 1'b0;
        wait_bits(1);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            @(negedge clk);
            sleep_req = mid_sleep && (i == 2);
            @(negedge clk);
            sleep_req = 1'b0;
            if (mid_sleep && i == 2) mid_sleep_seen = asleep;
            repeat (BIT_CLKS - 2) @(negedge clk);
        end
        rxd = stop;
        wait_bits(1);
        rxd = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 rx_data", rx_data, 9'h0);
        chk("R1 rx_ready", {8'h0, rx_ready}, 9'h0);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 flags", {6'h0, line_idle, frame_err, asleep}, 9'h0);
        wait_bits(2);

        // R2: 8-bit sweep
        for (int i = 0; i < 64; i++) begin
            logic [8:0] d;
            d = 9'((i * 37 + 11) & 8'hFF);
            send_char(d, 1'b1, 1'b0);
            chk("R2 ready 8-bit", {8'h0, rx_ready}, 9'h1);
            chk("R2 data 8-bit", rx_data, d);
            clr_all();
        end
        // R2: 9-bit sweep
        cfg_nine = 1'b1;
        for (int i = 0; i < 64; i++) begin
            logic [8:0] d;
            d = 9'((i * 149 + 3) & 9'h1FF);
            send_char(d, 1'b1, 1'b0);
            chk("R2 ready 9-bit", {8'h0, rx_ready}, 9'h1);
            chk("R2 data 9-bit", rx_data, d);
            clr_all();
        end
        cfg_nine = 1'b0;
        wait_bits(12);
        clr_all();

        // R3: short low pulse rejected, longer one accepted
        rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
        wait_bits(12);
        chk("R3 glitch no ready", {8'h0, rx_ready}, 9'h0);
        chk("R3 glitch no fe", {8'h0, frame_err}, 9'h0);
        send_char(9'h03C, 1'b1, 1'b0);
        chk("R3 after glitch data", rx_data, 9'h03C);
        clr_all();
        rxd = 1'b0; repeat (20) @(negedge clk); rxd = 1'b1;
        wait_bits(12);
        chk("R3 long low accepted", {rx_ready, rx_data}, {1'b1, 9'h0FF});
        clr_all();

        // R4: framing error
        send_char(9'h055, 1'b0, 1'b0);
        wait_bits(2);
        chk("R4 fe set", {7'h0, frame_err, rx_ready}, 9'h2);
        send_char(9'h066, 1'b1, 1'b0);
        chk("R4 blocked by fe", {8'h0, rx_ready}, 9'h0);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R4 fe cleared", {8'h0, frame_err}, 9'h0);
        send_char(9'h077, 1'b1, 1'b0);
        chk("R4 stored after clear", {rx_ready, rx_data}, {1'b1, 9'h077});
        wait_bits(12);

        // R5: clears are independent
        chk("R5 both set", {7'h0, rx_ready, line_idle}, 9'h3);
        @(negedge clk); idle_clr = 1'b1; @(negedge clk); idle_clr = 1'b0;
        chk("R5 idle_clr only", {7'h0, rx_ready, line_idle}, 9'h2);
        @(negedge clk); rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
        chk("R5 rdy_clr", {7'h0, rx_ready, line_idle}, 9'h0);

        // R7 / R6: idle start point and length
        send_char(9'h0FF, 1'b1, 1'b0);
        wait_bits(2);
        chk("R7 ilt0 idle early", {8'h0, line_idle}, 9'h1);
        clr_all();
        wait_bits(12);
        chk("R6 idle once", {8'h0, line_idle}, 9'h0);
        cfg_idle_after_stop = 1'b1;
        send_char(9'h0FF, 1'b1, 1'b0);
        wait_bits(2);
        chk("R7 ilt1 not yet", {8'h0, line_idle}, 9'h0);
        wait_bits(7);
        chk("R6 8-bit below limit", {8'h0, line_idle}, 9'h0);
        wait_bits(1);
        chk("R6 8-bit at limit", {8'h0, line_idle}, 9'h1);
        clr_all();
        cfg_nine = 1'b1;
        send_char(9'h1FF, 1'b1, 1'b0);
        wait_bits(10);
        chk("R6 9-bit below limit", {8'h0, line_idle}, 9'h0);
        wait_bits(1);
        chk("R6 9-bit at limit", {8'h0, line_idle}, 9'h1);
        cfg_nine = 1'b0;
        cfg_idle_after_stop = 1'b0;
        clr_all();

        // R8 / R9: idle-line wake, idle suppressed
        pulse_sleep();
        chk("R11 immediate sleep", {8'h0, asleep}, 9'h1);
        send_char(9'h012, 1'b1, 1'b0);
        wait_bits(1);
        chk("R8 no ready asleep", {7'h0, rx_ready, asleep}, 9'h1);
        send_char(9'h034, 1'b0, 1'b0);
        wait_bits(1);
        chk("R8 no fe asleep", {8'h0, frame_err}, 9'h0);
        wait_bits(12);
        chk("R9 woke, idle quiet", {7'h0, asleep, line_idle}, 9'h0);
        send_char(9'h056, 1'b1, 1'b0);
        chk("R9 stores after wake", {rx_ready, rx_data}, {1'b1, 9'h056});
        wait_bits(12);
        clr_all();
        cfg_idle_in_sleep = 1'b1;
        pulse_sleep();
        send_char(9'h021, 1'b1, 1'b0);
        wait_bits(12);
        chk("R9 idle reported asleep", {7'h0, asleep, line_idle}, 9'h1);
        cfg_idle_in_sleep = 1'b0;
        clr_all();

        // R10: address-bit wake
        cfg_wake_addr = 1'b1;
        pulse_sleep();
        send_char(9'h045, 1'b1, 1'b0);
        chk("R10 msb0 stays asleep", {7'h0, asleep, rx_ready}, 9'h2);
        wait_bits(12);
        chk("R10 idle no wake", {8'h0, asleep}, 9'h1);
        send_char(9'h0C5, 1'b1, 1'b0);
        chk("R10 addr wake 8-bit", {asleep, rx_ready, rx_data[6:0]}, {1'b0, 1'b1, 7'h45});
        chk("R10 addr data 8-bit", rx_data, 9'h0C5);
        clr_all();
        cfg_nine = 1'b1;
        pulse_sleep();
        send_char(9'h0C5, 1'b1, 1'b0);
        chk("R10 9-bit bit7 no wake", {7'h0, asleep, rx_ready}, 9'h2);
        send_char(9'h1A3, 1'b1, 1'b0);
        chk("R10 addr wake 9-bit", {7'h0, asleep, rx_ready}, 9'h1);
        chk("R10 addr data 9-bit", rx_data, 9'h1A3);
        cfg_nine = 1'b0;
        clr_all();

        // R11: request during a character
        send_char(9'h033, 1'b1, 1'b1);
        chk("R11 held mid-char", {8'h0, mid_sleep_seen}, 9'h0);
        chk("R11 char still stored", {rx_ready, rx_data}, {1'b1, 9'h033});
        chk("R11 applied at boundary", {8'h0, asleep}, 9'h1);
        send_char(9'h080, 1'b1, 1'b0);
        clr_all();
        send_char(9'h0B3, 1'b1, 1'b1);
        wait_bits(1);
        chk("R11 wake cancels held request", {7'h0, asleep, rx_ready}, 9'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule